// File: doc/BRIEF.md
# Control Endpoint Command and Status Register

This block holds the command and status state of a USB device's control endpoint. It sits between a simple CPU register bus and the transaction engine of the device. Firmware writes a command word. Some bits of that word are one-shot strobes that set or clear flags owned by hardware. Two bits are plain read/write fields. The transaction engine reports events as single-cycle pulses: SETUP received, OUT packet received, IN packet acknowledged by the host, status stage complete, and protocol violation. The block updates its flags from these pulses.

For each transaction the engine asks about, the block returns a registered handshake of ACK, NAK or STALL. STALL comes first and is driven by either a firmware stall field or a hardware-forced stall. The status stage comes next. The buffer-ready flags decide the rest. A sticky interrupt pending bit records two things: the data-end flag being cleared, which can be masked, and a forced stall starting, which cannot. A registered readback word shows every flag.

Command and status bit map, the same for writes and reads:
- bit 0: OUT buffer ready.
- bit 1: IN buffer ready.
- bit 2: data end.
- bit 3: forced stall.
- bit 4: send stall.
- bit 5: data-end interrupt mask.
- bit 6: interrupt pending.

Upper bits read as 0.

Top module: `ctlep_csr`

## Requirements
- R1: After synchronous reset, rd_data reads 0x20: only the data-end mask (bit 5) is 1. irq is 0 and hs_valid is 0.
- R2: The OUT-ready flag (bit 0) is set the cycle after an ev_setup or ev_out_pkt pulse. Writing 1 to bit 0 clears it. If a set event and the clearing write fall in the same cycle, the flag ends up 1.
- R3: The IN-ready flag (bit 1) is set by writing 1 to bit 1 and cleared by an ev_in_ack pulse. If both fall in the same cycle, the flag ends up 1.
- R4: Writing 1 to bit 2 sets the data-end flag, and writing 0 to bit 2 leaves it unchanged. An ev_status_done pulse clears it. When one write carries bit 2 together with bit 0 or bit 1, both changes take effect on the same edge.
- R5: Send stall (bit 4) and the data-end mask (bit 5) take the written value on every write.
- R6: An ev_violation pulse sets the forced-stall flag (bit 3). Writing 1 to bit 3 clears it. If both fall in the same cycle, the flag ends up 1.
- R7: The cycle after a tx_req, hs_valid is 1. hs_code is STALL (2'b11) when send stall or forced stall is 1, whatever the direction or other flags.
- R8: When there is no stall and the data-end flag is 1, hs_code is ACK (2'b01) for both IN and OUT, because the transaction is treated as the status stage.
- R9: Otherwise an IN transaction (tx_in=1) gets ACK if IN-ready is set and NAK (2'b10) if it is not. An OUT transaction gets NAK if OUT-ready is set and ACK if it is not. hs_valid is 0 in any cycle not preceded by tx_req.
- R10: A 1-to-0 change of the data-end flag sets the interrupt pending bit one cycle later while the mask is 0. It has no effect on the pending bit while the mask is 1.
- R11: A 0-to-1 change of forced stall sets the interrupt pending bit one cycle later, whatever the mask. Writing 1 to bit 6 clears the pending bit. irq equals the pending bit.
- R12: rd_data shows all flags at the bit positions listed above, with upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Command word |
| rd_data | output | DATA_W | Status readback |
| ev_setup | input | 1 | SETUP packet received |
| ev_out_pkt | input | 1 | OUT packet received |
| ev_in_ack | input | 1 | Host acknowledged IN packet |
| ev_status_done | input | 1 | Status stage complete |
| ev_violation | input | 1 | Protocol violation seen |
| tx_req | input | 1 | Handshake query for a transaction |
| tx_in | input | 1 | Query direction: 1 IN, 0 OUT |
| hs_valid | output | 1 | Handshake result valid |
| hs_code | output | 2 | 01 ACK, 10 NAK, 11 STALL |
| irq | output | 1 | Endpoint interrupt (pending bit) |

## Verification
The assertions check on every cycle the local update rules for flags:
- an OUT or SETUP event always leaves OUT-ready set;
- an acknowledged IN with no concurrent set clears IN-ready;
- a set-data-end write always shows;
- a clear-force-stall write with no concurrent violation takes effect;
- a stalled query always yields STALL.

Only the bench's scenarios can show the ordering effects:
- the full handshake priority across flag combinations;
- writes that combine data end with a buffer command;
- the interrupt appearing or staying quiet depending on the mask;
- the complete readback layout.

// File: rtl/ctlep_pkg.sv
package ctlep_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  localparam int B_OUT_CLR  = 0;
  localparam int B_IN_SET   = 1;
  localparam int B_DEND_SET = 2;
  localparam int B_FST_CLR  = 3;
  localparam int B_SSTALL   = 4;
  localparam int B_DMASK    = 5;
  localparam int B_IRQ_CLR  = 6;
  localparam int NUM_BITS   = 7;

  typedef struct packed {
    logic irq;
    logic dmask;
    logic sstall;
    logic fstall;
    logic dend;
    logic in_rdy;
    logic out_rdy;
  } stat_t;
endpackage

// File: rtl/ctlep_flags.sv
module ctlep_flags
  import ctlep_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [NUM_BITS-1:0] cmd,
  input  logic                ev_setup,
  input  logic                ev_out_pkt,
  input  logic                ev_in_ack,
  input  logic                ev_status_done,
  input  logic                ev_violation,
  output logic                out_rdy,
  output logic                in_rdy,
  output logic                dend,
  output logic                fstall,
  output logic                sstall,
  output logic                dmask
);
  logic w_out_clr, w_in_set, w_dend_set, w_fst_clr;

  always_comb begin
    w_out_clr  = wr_en & cmd[B_OUT_CLR];
    w_in_set   = wr_en & cmd[B_IN_SET];
    w_dend_set = wr_en & cmd[B_DEND_SET];
    w_fst_clr  = wr_en & cmd[B_FST_CLR];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_rdy <= 1'b0;
      in_rdy  <= 1'b0;
      dend    <= 1'b0;
      fstall  <= 1'b0;
      sstall  <= 1'b0;
      dmask   <= 1'b1;
    end else begin
      // hardware set beats firmware clear
      if (ev_setup | ev_out_pkt) out_rdy <= 1'b1;
      else if (w_out_clr)        out_rdy <= 1'b0;
      // firmware set beats acknowledge clear
      if (w_in_set)              in_rdy <= 1'b1;
      else if (ev_in_ack)        in_rdy <= 1'b0;
      if (w_dend_set)            dend <= 1'b1;
      else if (ev_status_done)   dend <= 1'b0;
      if (ev_violation)          fstall <= 1'b1;
      else if (w_fst_clr)        fstall <= 1'b0;
      if (wr_en) begin
        sstall <= cmd[B_SSTALL];
        dmask  <= cmd[B_DMASK];
      end
    end
  end

  a_r2_out_set: assert property (@(posedge clk) disable iff (rst)
    (ev_setup | ev_out_pkt) |=> out_rdy);
  a_r3_in_clear: assert property (@(posedge clk) disable iff (rst)
    (ev_in_ack && !(wr_en && cmd[B_IN_SET])) |=> !in_rdy);
  a_r4_dend_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cmd[B_DEND_SET]) |=> dend);
  a_r6_fstall_clr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cmd[B_FST_CLR] && !ev_violation) |=> !fstall);
endmodule

// File: rtl/ctlep_hs.sv
module ctlep_hs
  import ctlep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_req,
  input  logic       tx_in,
  input  logic       out_rdy,
  input  logic       in_rdy,
  input  logic       dend,
  input  logic       fstall,
  input  logic       sstall,
  output logic       hs_valid,
  output logic [1:0] hs_code
);
  hs_e pick;

  always_comb begin
    if (sstall | fstall)  pick = HS_STALL;
    else if (dend)        pick = HS_ACK;
    else if (tx_in)       pick = in_rdy ? HS_ACK : HS_NAK;
    else                  pick = out_rdy ? HS_NAK : HS_ACK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
    end else begin
      hs_valid <= tx_req;
      hs_code  <= tx_req ? pick : HS_NONE;
    end
  end

  a_r7_stall_wins: assert property (@(posedge clk) disable iff (rst)
    (tx_req && (sstall || fstall)) |=> (hs_valid && hs_code == HS_STALL));
endmodule

// File: rtl/ctlep_irq.sv
module ctlep_irq (
  input  logic clk,
  input  logic rst,
  input  logic dend,
  input  logic fstall,
  input  logic dmask,
  input  logic clr,
  output logic pend
);
  logic dend_d, fstall_d, set_ev;

  always_comb set_ev = (dend_d & ~dend & ~dmask) | (fstall & ~fstall_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      dend_d   <= 1'b0;
      fstall_d <= 1'b0;
      pend     <= 1'b0;
    end else begin
      dend_d   <= dend;
      fstall_d <= fstall;
      if (set_ev)   pend <= 1'b1;
      else if (clr) pend <= 1'b0;
    end
  end

  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_ev) |=> !pend);
endmodule

// File: rtl/ctlep_csr.sv
module ctlep_csr
  import ctlep_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_setup,
  input  logic              ev_out_pkt,
  input  logic              ev_in_ack,
  input  logic              ev_status_done,
  input  logic              ev_violation,
  input  logic              tx_req,
  input  logic              tx_in,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  output logic              irq
);
  localparam int PAD = DATA_W - NUM_BITS;

  stat_t st;
  logic  pend;
  logic  [NUM_BITS-1:0] cmd;

  always_comb cmd = wr_data[NUM_BITS-1:0];

  ctlep_flags u_flags (
    .clk(clk), .rst(rst), .wr_en(wr_en), .cmd(cmd),
    .ev_setup(ev_setup), .ev_out_pkt(ev_out_pkt), .ev_in_ack(ev_in_ack),
    .ev_status_done(ev_status_done), .ev_violation(ev_violation),
    .out_rdy(st.out_rdy), .in_rdy(st.in_rdy), .dend(st.dend),
    .fstall(st.fstall), .sstall(st.sstall), .dmask(st.dmask)
  );

  ctlep_hs u_hs (
    .clk(clk), .rst(rst), .tx_req(tx_req), .tx_in(tx_in),
    .out_rdy(st.out_rdy), .in_rdy(st.in_rdy), .dend(st.dend),
    .fstall(st.fstall), .sstall(st.sstall),
    .hs_valid(hs_valid), .hs_code(hs_code)
  );

  ctlep_irq u_irq (
    .clk(clk), .rst(rst), .dend(st.dend), .fstall(st.fstall),
    .dmask(st.dmask), .clr(wr_en & cmd[B_IRQ_CLR]), .pend(pend)
  );

  always_comb st.irq = pend;
  assign irq = pend;

  generate
    if (PAD > 0) begin : g_pad
      assign rd_data = {{PAD{1'b0}}, st};
    end else begin : g_nopad
      assign rd_data = st;
    end
  endgenerate
endmodule

// File: tb/ctlep_csr_tb.sv
module ctlep_csr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic ev_setup = 0, ev_out_pkt = 0, ev_in_ack = 0, ev_status_done = 0, ev_violation = 0;
  logic tx_req = 0, tx_in = 0;
  logic hs_valid, irq;
  logic [1:0] hs_code;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic sh_stall = 1'b0;
  logic sh_mask  = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlep_csr #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_setup(ev_setup), .ev_out_pkt(ev_out_pkt), .ev_in_ack(ev_in_ack),
    .ev_status_done(ev_status_done), .ev_violation(ev_violation),
    .tx_req(tx_req), .tx_in(tx_in), .hs_valid(hs_valid), .hs_code(hs_code), .irq(irq)
  );

  localparam logic [1:0] ACK = 2'b01, NAK = 2'b10, STL = 2'b11;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ev: {violation, status_done, in_ack, out_pkt, setup}
  task automatic step(input logic w, input logic [6:0] c, input logic [4:0] ev);
    @(negedge clk);
    wr_en = w;
    wr_data = {1'b0, c} | {2'b0, sh_mask, sh_stall, 4'b0};
    {ev_violation, ev_status_done, ev_in_ack, ev_out_pkt, ev_setup} = ev;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
    {ev_violation, ev_status_done, ev_in_ack, ev_out_pkt, ev_setup} = '0;
  endtask

  task automatic hs(input string req, input logic dir_in, input logic [1:0] exp);
    @(negedge clk);
    tx_req = 1; tx_in = dir_in;
    @(negedge clk);
    tx_req = 0;
    chk({req, " hs_valid"}, hs_valid, 1);
    chk({req, " hs_code"}, hs_code, exp);
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 8'h20);
    chk("R1 irq", irq, 0);
    chk("R1 hs_valid", hs_valid, 0);
  endtask

  task automatic t_out_rdy();
    step(0, 7'h00, 5'b00010);
    chk("R2 out set by packet", rd_data[0], 1);
    step(1, 7'h01, 5'b00000);
    chk("R2 out cleared", rd_data[0], 0);
    step(0, 7'h00, 5'b00001);
    chk("R2 out set by setup", rd_data[0], 1);
    step(1, 7'h01, 5'b00001);
    chk("R2 set wins over clear", rd_data[0], 1);
    step(1, 7'h01, 5'b00000);
  endtask

  task automatic t_in_rdy();
    step(1, 7'h02, 5'b00000);
    chk("R3 in set", rd_data[1], 1);
    step(0, 7'h00, 5'b00100);
    chk("R3 in cleared by ack", rd_data[1], 0);
    step(1, 7'h02, 5'b00100);
    chk("R3 set wins over ack", rd_data[1], 1);
    step(0, 7'h00, 5'b00100);
  endtask

  task automatic t_dend();
    step(1, 7'h00, 5'b00000);
    chk("R4 write 0 no effect", rd_data[2], 0);
    step(0, 7'h00, 5'b00010);
    step(1, 7'h05, 5'b00000);
    chk("R4 dend set", rd_data[2], 1);
    chk("R4 out cleared same write", rd_data[0], 0);
    step(0, 7'h00, 5'b01000);
    chk("R4 dend cleared by status", rd_data[2], 0);
    @(negedge clk);
    chk("R10 masked fall no irq", irq, 0);
    step(1, 7'h06, 5'b00000);
    chk("R4 dend with in set", rd_data[2:1], 2'b11);
    step(0, 7'h00, 5'b01100);
  endtask

  task automatic t_hs();
    hs("R9 out empty", 0, ACK);
    hs("R9 in empty", 1, NAK);
    @(negedge clk);
    chk("R9 hs_valid idle", hs_valid, 0);
    step(1, 7'h02, 5'b00000);
    hs("R9 in ready", 1, ACK);
    step(0, 7'h00, 5'b00010);
    hs("R9 out full", 0, NAK);
    step(1, 7'h04, 5'b00000);
    hs("R8 status in", 1, ACK);
    hs("R8 status out", 0, ACK);
    step(0, 7'h00, 5'b01000);
    sh_stall = 1;
    step(1, 7'h01, 5'b00000);
    chk("R5 stall field", rd_data[4], 1);
    hs("R7 send stall in", 1, STL);
    hs("R7 send stall out", 0, STL);
    sh_stall = 0;
    step(1, 7'h00, 5'b00000);
    chk("R5 stall field cleared", rd_data[4], 0);
    step(0, 7'h00, 5'b00100);
  endtask

  task automatic t_fstall();
    step(0, 7'h00, 5'b10000);
    chk("R6 fstall set", rd_data[3], 1);
    hs("R7 forced stall", 0, STL);
    chk("R11 irq on fstall", irq, 1);
    step(1, 7'h40, 5'b00000);
    chk("R11 irq cleared", irq, 0);
    step(1, 7'h08, 5'b00000);
    chk("R6 fstall cleared", rd_data[3], 0);
    step(1, 7'h08, 5'b10000);
    chk("R6 violation wins", rd_data[3], 1);
    step(1, 7'h08, 5'b00000);
    @(negedge clk);
    step(1, 7'h40, 5'b00000);
    chk("R11 irq cleared again", irq, 0);
  endtask

  task automatic t_irq_mask();
    sh_mask = 0;
    step(1, 7'h00, 5'b00000);
    chk("R5 mask field", rd_data[5], 0);
    step(1, 7'h04, 5'b00000);
    step(0, 7'h00, 5'b01000);
    @(negedge clk);
    chk("R10 unmasked fall irq", irq, 1);
    step(1, 7'h40, 5'b00000);
    chk("R10 irq cleared", irq, 0);
  endtask

  task automatic t_readback();
    step(0, 7'h00, 5'b00010);
    sh_stall = 1;
    step(1, 7'h06, 5'b00000);
    chk("R12 readback", rd_data, 8'h17);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_out_rdy();
    t_in_rdy();
    t_dend();
    t_hs();
    t_fstall();
    t_irq_mask();
    t_readback();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule